// File: doc/BRIEF.md
# Packed SIMD Bit-Immediate Unit

This unit applies a single immediate-controlled operation to every lane of a 128-bit packed vector in one pass. A 7-bit prefix-coded control field carries both the lane width (8, 16, 32 or 64 bits) and an immediate `m`. The available operations are:

- shifts: left, logical right and arithmetic right;
- single-bit edits: clear, set and invert;
- rounding right shifts, both arithmetic and logical;
- saturation to an `m`-defined range, signed or unsigned.

Results go to a single output register. Operands enter on a valid/ready stream and results leave on another. The output register is the only storage. Back-pressure works as follows:

- A beat is accepted when `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty, or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the output holds and no new beat is taken.

A field value in the reserved range, or an unknown operation code, still produces an output beat. That beat has `out_illegal` set, and the result vector keeps its previous contents.

Top module: `simd_bit_unit`

## Requirements
- R1: The field is decoded by prefix. `0mmmmmm` selects 64-bit lanes with m = bits 5:0. `10mmmmm` selects 32-bit lanes with m = bits 4:0. `110mmmm` selects 16-bit lanes with m = bits 3:0. `1110mmm` selects 8-bit lanes with m = bits 2:0. Lane i occupies bits [(i+1)W-1 : iW].
- R2: An accepted beat raises `out_illegal` with the resulting output beat, and leaves `out_vec` unchanged, in either of two cases: the field is `1111xxx`, or the opcode is 10 to 15.
- R3: Opcode 0 shifts each lane left by m, with zeros filling from the bottom. Field 0 with opcode 0 returns the input unchanged.
- R4: Opcode 1 shifts each lane right by m and replicates the lane sign bit. Opcode 2 shifts each lane right by m and fills with zeros.
- R5: Opcodes 3, 4 and 5 act on lane bit m only: 3 clears it, 4 sets it and 5 inverts it. All other bits are unchanged.
- R6: Opcode 6 (arithmetic) and opcode 7 (logical) are rounding right shifts. With m = 0 the lane is returned unchanged. Otherwise the result is the lane shifted right by m, plus lane bit m-1, truncated to W bits.
- R7: Opcode 8 clamps each signed lane to the range -2^m to 2^m-1.
- R8: Opcode 9 treats each lane as unsigned and clamps it to at most 2^(m+1)-1.
- R9: Every lane is computed independently, using the same operation and m.
- R10: An accepted beat appears on the output at the next clock edge with `out_valid` high. An output that is drained with no new beat accepted drops `out_valid` at the next clock edge.
- R11: `in_ready` is low while `out_valid` is high and `out_ready` is low. During such a stall, `out_vec`, `out_illegal` and `out_valid` hold.
- R12: Synchronous reset clears `out_valid`, `out_illegal` and `out_vec` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_op | input | 4 | Operation code (0 to 9 legal) |
| in_field | input | 7 | Prefix-coded lane width and immediate |
| in_vec | input | 128 | Source vector |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_vec | output | 128 | Result vector |
| out_illegal | output | 1 | Beat carried a reserved field or opcode |

## Verification
There is only one register stage, so a fault in the lane datapath or in the width decode shows up on `out_vec` in the very next output beat. Because lanes are checked together, a fault appears as one wrong lane, or as a repeated wrong pattern across lanes. A corrupted output register, or faulty valid/ready state, shows up within one cycle in one of three ways: a beat that vanishes, a beat that is duplicated, or data that changes while stalled. The sweep covers every operation, every lane width and every legal immediate, so an off-by-one in a shift amount, a rounding bit or a saturation bound shows up at its own exact m.

// File: rtl/simd_bit_pkg.sv
package simd_bit_pkg;
  localparam int FIELD_W    = 7;
  localparam int IMM_W      = 6;
  localparam int OP_W       = 4;
  localparam int NUM_WIDTHS = 4;
  localparam int MIN_LANE_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_SLL  = 4'd0,
    OP_SRA  = 4'd1,
    OP_SRL  = 4'd2,
    OP_BCLR = 4'd3,
    OP_BSET = 4'd4,
    OP_BNEG = 4'd5,
    OP_SRAR = 4'd6,
    OP_SRLR = 4'd7,
    OP_SATS = 4'd8,
    OP_SATU = 4'd9
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd9;

  typedef enum logic [1:0] {
    LW8  = 2'd0,
    LW16 = 2'd1,
    LW32 = 2'd2,
    LW64 = 2'd3
  } lane_w_e;
endpackage

// File: rtl/simd_bit_decode.sv
module simd_bit_decode
  import simd_bit_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  output lane_w_e            wsel,
  output logic [IMM_W-1:0]   imm,
  output logic               reserved
);
  // The leading ones count picks the width; the rest of the field is m.
  always_comb begin
    wsel     = LW64;
    imm      = '0;
    reserved = 1'b0;
    if (!field[6]) begin
      wsel = LW64;
      imm  = field[5:0];
    end else if (!field[5]) begin
      wsel = LW32;
      imm  = {1'b0, field[4:0]};
    end else if (!field[4]) begin
      wsel = LW16;
      imm  = {2'b00, field[3:0]};
    end else if (!field[3]) begin
      wsel = LW8;
      imm  = {3'b000, field[2:0]};
    end else begin
      reserved = 1'b1;
    end
  end
endmodule

// File: rtl/simd_bit_lane.sv
module simd_bit_lane
  import simd_bit_pkg::*;
#(
  parameter int LW = 8
) (
  input  op_e                      op,
  input  logic [$clog2(LW)-1:0]    k,
  input  logic [LW-1:0]            x,
  output logic [LW-1:0]            y
);
  localparam int IDX_W = $clog2(LW);
  localparam logic [IDX_W-1:0] K_ONE = 1;
  localparam logic [LW:0]      ONE_W = 1;
  localparam logic [IDX_W:0]   KP_ONE = 1;

  logic signed [LW-1:0] sx;
  logic [LW-1:0]        onehot, sll_r, srl_r, sra_r, rbit_v;
  logic                 rbit;
  logic [LW:0]          p2, ub;
  logic [IDX_W:0]       kp1;
  logic signed [LW:0]   ext, hi, lo;

  always_comb begin
    sx     = x;
    onehot = {{(LW-1){1'b0}}, 1'b1} << k;
    sll_r  = x << k;
    srl_r  = x >> k;
    sra_r  = sx >>> k;
    rbit   = (k == '0) ? 1'b0 : x[k - K_ONE];
    rbit_v = {{(LW-1){1'b0}}, rbit};
    // signed bounds of an (k+1)-bit integer, held one bit wider than the lane
    p2     = ONE_W << k;
    hi     = $signed(p2 - ONE_W);
    lo     = -$signed(p2);
    ext    = {x[LW-1], x};
    kp1    = {1'b0, k} + KP_ONE;
    ub     = (ONE_W << kp1) - ONE_W;
  end

  always_comb begin
    case (op)
      OP_SLL:  y = sll_r;
      OP_SRA:  y = sra_r;
      OP_SRL:  y = srl_r;
      OP_BCLR: y = x & ~onehot;
      OP_BSET: y = x | onehot;
      OP_BNEG: y = x ^ onehot;
      OP_SRAR: y = (k == '0) ? x : sra_r + rbit_v;
      OP_SRLR: y = (k == '0) ? x : srl_r + rbit_v;
      OP_SATS: y = (ext > hi) ? hi[LW-1:0] : ((ext < lo) ? lo[LW-1:0] : x);
      OP_SATU: y = ({1'b0, x} > ub) ? ub[LW-1:0] : x;
      default: y = x;
    endcase
  end
endmodule

// File: rtl/simd_bit_unit.sv
module simd_bit_unit
  import simd_bit_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [6:0]        in_field,
  input  logic [DATA_W-1:0] in_vec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_vec,
  output logic              out_illegal
);
  lane_w_e                             wsel;
  logic [IMM_W-1:0]                    imm;
  logic                                rsvd_field;
  logic                                illegal;
  logic                                accept;
  logic [NUM_WIDTHS-1:0][DATA_W-1:0]   res_w;
  logic [DATA_W-1:0]                   res;

  simd_bit_decode u_dec (
    .field    (in_field),
    .wsel     (wsel),
    .imm      (imm),
    .reserved (rsvd_field)
  );

  // One full-vector lane array per width; the decoded width picks one.
  for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_width
    localparam int LW = MIN_LANE_W << gi;
    localparam int NL = DATA_W / LW;
    for (genvar li = 0; li < NL; li++) begin : g_lane
      simd_bit_lane #(.LW(LW)) u_lane (
        .op (op_e'(in_op)),
        .k  (imm[$clog2(LW)-1:0]),
        .x  (in_vec[li*LW +: LW]),
        .y  (res_w[gi][li*LW +: LW])
      );
    end
  end

  assign res      = res_w[wsel];
  assign illegal  = rsvd_field || (in_op > OP_LAST);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_vec     <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_illegal <= illegal;
      if (!illegal) out_vec <= res;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_bit_unit_chk.sv
module simd_bit_unit_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic [6:0]        in_field,
  input logic [DATA_W-1:0] in_vec,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_vec,
  input logic              out_illegal
);
  assert_accept_yields_valid_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_illegal)));

  assert_reserved_keeps_data_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_field[6:3] == 4'hF) |=> (out_illegal && $stable(out_vec)));

  assert_zero_shift_passthru_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 4'd0 && in_field == 7'h00)
      |=> (out_vec == $past(in_vec) && !out_illegal));
endmodule

bind simd_bit_unit simd_bit_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_field    (in_field),
  .in_vec      (in_vec),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_vec     (out_vec),
  .out_illegal (out_illegal)
);

// File: tb/simd_bit_unit_test.sv
`timescale 1ns/1ps
module simd_bit_unit_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_op = '0;
  logic [6:0]   in_field = '0;
  logic [127:0] in_vec = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_vec;
  logic         out_illegal;

  int applied = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [63:0] s0 = 64'h9E3779B97F4A7C15;
  logic [63:0] s1 = 64'hD1B54A32D192ED03;

  always #2 clk = ~clk;

  simd_bit_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_field(in_field), .in_vec(in_vec),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_vec(out_vec), .out_illegal(out_illegal)
  );

  function automatic logic [63:0] xs(logic [63:0] v);
    logic [63:0] t = v;
    t ^= t << 13; t ^= t >> 7; t ^= t << 17;
    return t;
  endfunction

  function automatic logic [6:0] mk_field(int w, int m);
    case (w)
      64: return {1'b0, 6'(m)};
      32: return {2'b10, 5'(m)};
      16: return {3'b110, 4'(m)};
      default: return {4'b1110, 3'(m)};
    endcase
  endfunction

  function automatic logic [63:0] ref_lane(int op, int w, int m, logic [63:0] xin);
    logic [63:0] mask, x;
    logic signed [65:0] sx, hi, lo, r;
    logic [65:0] ub;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    x  = xin & mask;
    sx = $signed({2'b00, x});
    if (x[w-1]) sx = sx - (66'sd1 <<< w);
    case (op)
      0: r = $signed({2'b00, x} << m);
      1: r = sx >>> m;
      2: r = $signed({2'b00, x >> m});
      3: r = $signed({2'b00, x & ~(64'd1 << m)});
      4: r = $signed({2'b00, x | (64'd1 << m)});
      5: r = $signed({2'b00, x ^ (64'd1 << m)});
      6: r = (m == 0) ? sx : (sx >>> m) + $signed({65'd0, x[m-1]});
      7: r = (m == 0) ? $signed({2'b00, x}) : $signed({2'b00, x >> m}) + $signed({65'd0, x[m-1]});
      8: begin
        hi = (66'sd1 <<< m) - 66'sd1;
        lo = -(66'sd1 <<< m);
        r  = (sx > hi) ? hi : ((sx < lo) ? lo : sx);
      end
      default: begin
        ub = (66'd1 << (m + 1)) - 66'd1;
        r  = ({2'b00, x} > ub) ? $signed(ub) : $signed({2'b00, x});
      end
    endcase
    return r[63:0] & mask;
  endfunction

  function automatic logic [127:0] ref_vec(int op, int w, int m, logic [127:0] v);
    logic [127:0] e = '0;
    for (int li = 0; li < 128 / w; li++)
      e |= {64'd0, ref_lane(op, w, m, v[li*w +: 64])} << (li * w);
    return e;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one beat with out_ready high, then look at the registered result
  task automatic apply(int op, logic [6:0] f, logic [127:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'(op); in_field = f; in_vec = v;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string req_of(int op);
    case (op)
      0: return "R3"; 1, 2: return "R4"; 3, 4, 5: return "R5";
      6, 7: return "R6"; 8: return "R7"; default: return "R8";
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [127:0] v, prev, a_exp, b_exp;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    check("R12 out_valid", {127'd0, out_valid}, 128'd0);
    check("R12 out_illegal", {127'd0, out_illegal}, 128'd0);
    check("R12 out_vec", out_vec, 128'd0);
    check("R11 in_ready idle", {127'd0, in_ready}, 128'd1);

    // R1 R9: sweep every width, operation and immediate over several patterns
    for (int op = 0; op < 10; op++) begin
      for (int wi = 0; wi < 4; wi++) begin
        int w = 8 << wi;
        for (int m = 0; m < w; m++) begin
          for (int p = 0; p < 3; p++) begin
            if (p == 2) v = 128'h7F80_FF00_8001_7FFF_0000_FFFF_8000_0001;
            else begin
              s0 = xs(s0); s1 = xs(s1);
              v = {s0, s1};
            end
            apply(op, mk_field(w, m), v);
            check({req_of(op), " R1 R9 R10 data"}, out_vec, ref_vec(op, w, m, v));
            check({req_of(op), " R10 valid"}, {126'd0, out_valid, out_illegal}, 128'd2);
          end
        end
      end
    end

    // R3: zero shift on 64-bit lanes passes input through
    v = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE;
    apply(0, 7'h00, v);
    check("R3 passthru", out_vec, v);

    // R2: reserved field keeps prior result, flags illegal
    prev = out_vec;
    apply(0, 7'b1111_010, ~v);
    check("R2 reserved field data", out_vec, prev);
    check("R2 reserved field flag", {127'd0, out_illegal}, 128'd1);
    apply(4'd12, 7'h05, ~v);
    check("R2 reserved opcode data", out_vec, prev);
    check("R2 reserved opcode flag", {127'd0, out_illegal}, 128'd1);
    apply(2, mk_field(8, 1), v);
    check("R2 flag clears on legal", {127'd0, out_illegal}, 128'd0);

    // R10: drained with nothing new drops valid
    @(negedge clk);
    check("R10 drop valid", {127'd0, out_valid}, 128'd0);

    // R11: stall holds output and blocks input
    out_ready = 1'b0;
    s0 = xs(s0); v = {s0, ~s0};
    a_exp = ref_vec(1, 16, 5, v);
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'd1; in_field = mk_field(16, 5); in_vec = v;
    @(negedge clk);
    check("R11 first beat", out_vec, a_exp);
    check("R11 in_ready low", {127'd0, in_ready}, 128'd0);
    s1 = xs(s1); v = {~s1, s1};
    b_exp = ref_vec(9, 32, 20, v);
    in_op = 4'd9; in_field = mk_field(32, 20); in_vec = v;
    repeat (2) @(negedge clk);
    check("R11 hold data", out_vec, a_exp);
    check("R11 hold valid", {127'd0, out_valid}, 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 next beat after release", out_vec, b_exp);
    check("R11 valid after release", {127'd0, out_valid}, 128'd1);

    // R12: reset mid-stream clears the output register
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 reset clears data", out_vec, 128'd0);
    check("R12 reset clears valid", {127'd0, out_valid}, 128'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule